// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block holds the DMA controller's shared interrupt control and flag word. It also gates the start of each transfer channel. Software writes the word to set per-channel interrupt enables, a global enable and a force bit. Completion pulses from the channels set the per-channel flags. Software clears a flag by writing a one to it.

Whenever the interrupt condition goes from false to true, the block sends exactly one single-cycle pulse to the system interrupt controller. It then records that the interrupt went out in a sticky top bit. That bit drops again when the condition goes away, so a later event can raise a fresh pulse.

The start gating watches writes to the channel control registers. Channel n has its control register at byte offset 0x088 + 0x10·n; the interrupt word sits at 0x0F4. A write to a channel control register with bit 24 set produces a start pulse for that channel. The pulse appears only if the channel's start-enable bit (bit 3+4n of the neighbouring priority/enable register) is set.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset, `icr_rdata` reads 0, and `irq_pulse` and `chan_start` are low.
- R2: A write to offset 0x0F4 loads only the bits under mask 0x00FF803F: bits 0–5, force bit 15, channel enables 16–22 and global enable 23. Bits 6–14 read 0, and bit 31 cannot be written.
- R3: Flag bits 24–30 are cleared by writing 1 to them and are kept by writing 0.
- R4: A completion pulse on `chan_done[n]` sets flag 24+n on the next clock, but only if enable bit 16+n is set at that time.
- R5: The interrupt condition is (bit 23 AND any flag in 24–30) OR bit 15. When it turns true while bit 31 is clear, `irq_pulse` is high for exactly one cycle, and in that same cycle bit 31 reads 1.
- R6: While the condition stays true with bit 31 set, no further pulse is produced, even if more flags get set.
- R7: Bit 31 clears in the cycle the condition becomes false, so a later event produces a new pulse.
- R8: Setting force bit 15 alone raises the condition, whatever the flags and the global enable.
- R9: A write to offset 0x088+0x10·n with data bit 24 set gives a one-cycle pulse on `chan_start[n]` in the next cycle, but only when `chan_enable[n]` is 1. Otherwise no start pulse appears.
- R10: Writes to any offset other than 0x0F4 leave the interrupt word unchanged.
- R11: When a flag is cleared by software in the same cycle that its channel completes (with its enable set), the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the write |
| reg_wdata | input | 32 | Write data |
| chan_enable | input | NCH | Start-enable bit of each channel, taken from bit 3+4n of the priority/enable register |
| chan_done | input | NCH | Per-channel completion pulses |
| icr_rdata | output | 32 | Current interrupt word, including flags and bit 31 |
| chan_start | output | NCH | One-cycle start request per channel |
| irq_pulse | output | 1 | One-cycle pulse to the system interrupt controller |

## Verification
The bench targets the following corner cases:
- A flag that is cleared and set in the same cycle. A design that gives the clear priority would lose that completion.
- A second completion arriving while the interrupt is already pending. A design without the sticky bit would pulse twice for one burst.
- The condition going false and then true again. A design whose sent bit never releases would stay silent on the second event.
- Flags collected while the global enable is off, then released by setting it. A design that ignores the global enable would pulse early.
- Writes to the wrong offset, to the non-writable bits, and start writes with the channel disabled. Each of these would wrongly change the word or start a channel.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int          WORD_W        = 32;
    localparam logic [31:0] WR_MASK       = 32'h00FF_803F;
    localparam int          FORCE_BIT     = 15;
    localparam int          EN_LSB        = 16;
    localparam int          GLOBAL_EN_BIT = 23;
    localparam int          FLAG_LSB      = 24;
    localparam int          FLAG_W        = 7;
    localparam int          SENT_BIT      = 31;
    localparam int          START_BIT     = 24;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              irq;
    } icr_state_t;
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int NCH     = 7,
    parameter int ADDR_W  = 12,
    parameter int ICR_OFS = 'h0F4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NCH-1:0]    done,
    output logic [WORD_W-1:0] word,
    output logic              irq
);
    icr_state_t state_d, state_q;
    logic       hit;
    logic [FLAG_W-1:0] flags;
    logic       cond;

    always_comb begin
        state_d = state_q;
        hit     = wr_en && (wr_addr == ADDR_W'(ICR_OFS));
        flags   = state_q.word[FLAG_LSB +: FLAG_W];
        if (hit) begin
            state_d.word = wr_data & WR_MASK;
            flags        = flags & ~wr_data[FLAG_LSB +: FLAG_W];
        end
        // set after clear: a completion in the same cycle wins (R11)
        for (int n = 0; n < NCH; n++) begin
            if (done[n] && state_q.word[EN_LSB + n])
                flags[n] = 1'b1;
        end
        state_d.word[FLAG_LSB +: FLAG_W] = flags;
        cond = (state_d.word[GLOBAL_EN_BIT] && (|flags)) || state_d.word[FORCE_BIT];
        state_d.word[SENT_BIT] = cond;
        state_d.irq            = cond && !state_q.word[SENT_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign word = state_q.word;
    assign irq  = state_q.irq;

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ICR_OFS)) |=>
            (word[23:16] == $past(wr_data[23:16]) && word[5:0] == $past(wr_data[5:0])));

    p_force_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ICR_OFS) && wr_data[FORCE_BIT]) |=> word[SENT_BIT]);

    p_pulse_has_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (word[SENT_BIT] &&
                 ((word[GLOBAL_EN_BIT] && (|word[FLAG_LSB +: FLAG_W])) || word[FORCE_BIT])));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_other_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && done == '0) |=> $stable(word[23:0]));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_flag_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(word[FLAG_LSB + g]) |-> ($past(done[g]) && $past(word[EN_LSB + g])));
        p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(ICR_OFS) && wr_data[FLAG_LSB + g] && !done[g])
                |=> !word[FLAG_LSB + g]);
    end
endmodule

// File: rtl/dma_start_gate.sv
module dma_start_gate #(
    parameter int NCH       = 7,
    parameter int ADDR_W    = 12,
    parameter int CH_BASE   = 'h088,
    parameter int CH_STRIDE = 'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              start_bit,
    input  logic [NCH-1:0]    enable,
    output logic [NCH-1:0]    start
);
    logic [NCH-1:0] start_d, start_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_OFS = ADDR_W'(CH_BASE + g * CH_STRIDE);
        always_comb begin
            start_d[g] = wr_en && (wr_addr == CH_OFS) && start_bit && enable[g];
        end

        p_start_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
            start_q[g] |-> ($past(enable[g]) && $past(wr_en) && $past(start_bit)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= '0;
        else        start_q <= start_d;
    end

    assign start = start_q;

    p_start_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_q));
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int NCH       = 7,
    parameter int ADDR_W    = 12,
    parameter int ICR_OFS   = 'h0F4,
    parameter int CH_BASE   = 'h088,
    parameter int CH_STRIDE = 'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [NCH-1:0]    chan_enable,
    input  logic [NCH-1:0]    chan_done,
    output logic [31:0]       icr_rdata,
    output logic [NCH-1:0]    chan_start,
    output logic              irq_pulse
);
    dma_irq_flags #(
        .NCH     (NCH),
        .ADDR_W  (ADDR_W),
        .ICR_OFS (ICR_OFS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .done    (chan_done),
        .word    (icr_rdata),
        .irq     (irq_pulse)
    );

    dma_start_gate #(
        .NCH       (NCH),
        .ADDR_W    (ADDR_W),
        .CH_BASE   (CH_BASE),
        .CH_STRIDE (CH_STRIDE)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .start_bit (reg_wdata[START_BIT]),
        .enable    (chan_enable),
        .start     (chan_start)
    );
endmodule

// File: tb/dma_irq_unit_tb.sv
module dma_irq_unit_tb;
    localparam int NCH   = 7;
    localparam int NVEC  = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [NCH-1:0] chan_enable = '0;
    logic [NCH-1:0] chan_done = '0;
    logic [31:0] icr_rdata;
    logic [NCH-1:0] chan_start;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    dma_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .chan_enable(chan_enable), .chan_done(chan_done),
        .icr_rdata(icr_rdata), .chan_start(chan_start), .irq_pulse(irq_pulse)
    );

    typedef struct {
        bit          wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [6:0]  done;
        logic [6:0]  en;
        logic [31:0] exp_rd;
        bit          exp_irq;
        logic [6:0]  exp_start;
        string       req;
    } vec_t;

    function automatic vec_t get_vec(int i);
        vec_t v;
        v = '{0, 12'h000, 32'h0, 7'h0, 7'h0, 32'h0, 0, 7'h0, "R1"};
        case (i)
            0:  v = '{1, 12'h0F4, 32'hFFFF_FFFF, 7'h00, 7'h00, 32'h80FF_803F, 1, 7'h00, "R2"};
            1:  v = '{0, 12'h000, 32'h0,         7'h00, 7'h00, 32'h80FF_803F, 0, 7'h00, "R6"};
            2:  v = '{1, 12'h0F4, 32'h0,         7'h00, 7'h00, 32'h0000_0000, 0, 7'h00, "R7"};
            3:  v = '{1, 12'h0F4, 32'h0083_0000, 7'h00, 7'h00, 32'h0083_0000, 0, 7'h00, "R2"};
            4:  v = '{0, 12'h000, 32'h0,         7'h04, 7'h00, 32'h0083_0000, 0, 7'h00, "R4"};
            5:  v = '{0, 12'h000, 32'h0,         7'h01, 7'h00, 32'h8183_0000, 1, 7'h00, "R5"};
            6:  v = '{0, 12'h000, 32'h0,         7'h02, 7'h00, 32'h8383_0000, 0, 7'h00, "R6"};
            7:  v = '{1, 12'h0F4, 32'h0183_0000, 7'h00, 7'h00, 32'h8283_0000, 0, 7'h00, "R3"};
            8:  v = '{1, 12'h0F4, 32'h0283_0000, 7'h02, 7'h00, 32'h8283_0000, 0, 7'h00, "R11"};
            9:  v = '{1, 12'h0F4, 32'h0283_0000, 7'h00, 7'h00, 32'h0083_0000, 0, 7'h00, "R7"};
            10: v = '{0, 12'h000, 32'h0,         7'h01, 7'h00, 32'h8183_0000, 1, 7'h00, "R7"};
            11: v = '{1, 12'h0F4, 32'h7F03_0000, 7'h00, 7'h00, 32'h0003_0000, 0, 7'h00, "R3"};
            12: v = '{0, 12'h000, 32'h0,         7'h01, 7'h00, 32'h0103_0000, 0, 7'h00, "R5"};
            13: v = '{1, 12'h0F4, 32'h0083_0000, 7'h00, 7'h00, 32'h8183_0000, 1, 7'h00, "R5"};
            14: v = '{1, 12'h0F4, 32'h0100_0000, 7'h00, 7'h00, 32'h0000_0000, 0, 7'h00, "R3"};
            15: v = '{1, 12'h0F4, 32'h8000_7FC0, 7'h00, 7'h00, 32'h0000_0000, 0, 7'h00, "R2"};
            16: v = '{1, 12'h0F0, 32'hFFFF_FFFF, 7'h00, 7'h7F, 32'h0000_0000, 0, 7'h00, "R10"};
            17: v = '{1, 12'h0A8, 32'h0100_0000, 7'h00, 7'h04, 32'h0000_0000, 0, 7'h04, "R9"};
            18: v = '{1, 12'h0A8, 32'h0100_0000, 7'h00, 7'h01, 32'h0000_0000, 0, 7'h00, "R9"};
            19: v = '{1, 12'h0E8, 32'h0100_0000, 7'h00, 7'h40, 32'h0000_0000, 0, 7'h40, "R9"};
            20: v = '{1, 12'h0E8, 32'h0000_0000, 7'h00, 7'h7F, 32'h0000_0000, 0, 7'h00, "R9"};
            21: v = '{1, 12'h0F4, 32'h0000_8000, 7'h00, 7'h00, 32'h8000_8000, 1, 7'h00, "R8"};
            default: ;
        endcase
        return v;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(bit wr, logic [11:0] a, logic [31:0] d, logic [6:0] dn, logic [6:0] en);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; chan_done = dn; chan_enable = en;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; chan_done = '0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "rdata", icr_rdata, 32'h0);
        check("R1", "irq", {31'h0, irq_pulse}, 32'h0);
        check("R1", "start", {25'h0, chan_start}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = get_vec(i);
            step(v.wr, v.addr, v.data, v.done, v.en);
            check(v.req, "rdata", icr_rdata, v.exp_rd);
            check(v.req, "irq", {31'h0, irq_pulse}, {31'h0, v.exp_irq});
            check(v.req, "start", {25'h0, chan_start}, {25'h0, v.exp_start});
        end

        // R8: force held, no second pulse; clearing force drops bit 31
        step(0, 12'h000, 32'h0, 7'h00, 7'h00);
        check("R8", "irq held", {31'h0, irq_pulse}, 32'h0);
        step(1, 12'h0F4, 32'h0, 7'h00, 7'h00);
        check("R7", "sent cleared", icr_rdata, 32'h0);

        // R4: enable dropped in same write as completion uses the old enable
        step(1, 12'h0F4, 32'h0040_0000, 7'h00, 7'h00);
        step(1, 12'h0F4, 32'h0000_0000, 7'h40, 7'h00);
        check("R4", "old enable", icr_rdata, 32'h4000_0000);

        // R1: reset mid-run returns to idle
        step(1, 12'h0F4, 32'h0000_8000, 7'h00, 7'h00);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "rdata after reset", icr_rdata, 32'h0);
        check("R1", "irq after reset", {31'h0, irq_pulse}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        finish_run();
    end
endmodule